// File: doc/BRIEF.md
# Timed code-check result indicator

This block takes a four-bit code that an operator keys in one bit at a time and drives three indicator lines. Each entry step waits for a single-cycle button strobe. On that strobe the block samples one fixed bit of an eight-bit switch input. After the fourth step the block spends one cycle judging the code. It then shows either a pass or a fail indicator for a fixed time, and returns to the first entry step.

The two hold times are given in seconds and converted to clock cycles through a clock-frequency parameter. A single loadable down-counter times both holds. The counter is loaded with a value chosen by the result state being entered. A one-cycle completion pulse marks the end of every hold. Debouncing of the button and the switches happens outside the block. So does driving the actual lamps.

Top module: `code_check_indicator`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. While it is low, and after it is released, `ind` is 100 and `done` is 0. Release always resumes at the first entry step, whether reset came during entry or during a hold. A complete four-strobe entry is then needed.
- R2: `ind` is {busy, pass, fail}, from bit 2 down to bit 0. It is 100 during every entry step and during the check cycle.
- R3: Entry steps 0, 1, 2 and 3 sample `code_in` bits 7, 6, 5 and 3 in that order, on the strobe that ends the step. The other four bits of `code_in` never affect the result.
- R4: An entry step advances only on a cycle with `strobe` high. Without a strobe the block stays in the same step with `ind` at 100 for any number of cycles.
- R5: The cycle after the fourth strobe is a check cycle with `ind` 100. The next cycle starts the pass hold if all four sampled bits were 1. Any other combination starts the fail hold.
- R6: The pass hold shows `ind` = 010 for exactly PASS_SEC × CLK_HZ consecutive cycles.
- R7: The fail hold shows `ind` = 001 for exactly FAIL_SEC × CLK_HZ consecutive cycles.
- R8: `done` is high for exactly one cycle: the first cycle after a hold ends. In that cycle `ind` is already 100 and the block is at entry step 0. `done` is low at all other times.
- R9: Strobes in the check cycle or in any hold cycle, including the last one, are ignored. The hold length does not change, and the next code still needs four strobes after the hold.
- R10: A strobe in the cycle where `done` is high is taken as entry step 0 of the next code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock of frequency CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe | input | 1 | Debounced single-cycle button event that ends one entry step |
| code_in | input | 8 | Switch inputs; bits 7, 6, 5 and 3 are sampled |
| ind | output | 3 | Indicator lines {busy, pass, fail} |
| done | output | 1 | One-cycle pulse after a hold has finished |

## Verification
The end of a hold, marked by `done`, can fall in the same cycle as a capture for entry step 0 of the next code. The bench provokes this by raising the strobe in exactly the cycle where it observes `done`. It then keys only the remaining three steps, so the next result is correct only if that strobe's bit 7 was kept. The bench also drives a strobe one cycle earlier, in the last hold cycle, and checks that it was dropped: the measured hold length is unchanged and a full four-strobe entry is still required.

// File: rtl/cci_pkg.sv
// Package for the code-check indicator.
// Holds the phase encoding, the input width and the map from entry step
// to sampled input bit. Assumes the code input is eight bits wide.
package cci_pkg;

    // Phase of the controller
    typedef enum logic [1:0] {
        PH_ENTRY = 2'd0,
        PH_CHECK = 2'd1,
        PH_PASS  = 2'd2,
        PH_FAIL  = 2'd3
    } phase_t;

    localparam int CODE_W   = 8;
    localparam int IDX_W    = $clog2(CODE_W);
    localparam int NUM_TAPS = 4;

    // Input bit sampled at each step; step 0 occupies the low field.
    // Steps 0..3 take bits 7, 6, 5, 3.
    localparam logic [NUM_TAPS*IDX_W-1:0] TAP_MAP = {3'd3, 3'd5, 3'd6, 3'd7};

endpackage

// File: rtl/cci_capture.sv
// Step counter and captured code bits.
// On every 'take' it stores the input bit mapped to the current step and
// moves to the next step, wrapping after the last one. Assumes 'take' is
// only raised by the controller while it is in the entry phase.
module cci_capture
    import cci_pkg::*;
#(
    parameter int STEPS = NUM_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [CODE_W-1:0] code_in,
    output logic              last_step,
    output logic              code_ok
);
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

    logic [STEP_W-1:0] step_q;
    logic [STEPS-1:0]  cap_q;
    logic              unused_code;

    assign last_step = (step_q == LAST);
    assign code_ok   = &cap_q;
    // Fold of the inputs so that bits no step samples count as read
    assign unused_code = ^code_in;

    // Step index: advances on take, wraps after the last step
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= '0;
        else if (take)
            step_q <= last_step ? '0 : step_q + 1'b1;
    end

    // One capture flop per step, each tied to its own input bit
    for (genvar g = 0; g < STEPS; g++) begin : g_cap
        localparam int BIT = int'(TAP_MAP[g*IDX_W +: IDX_W]);
        always_ff @(posedge clk) begin
            if (!rst_n)
                cap_q[g] <= 1'b0;
            else if (take && step_q == STEP_W'(g))
                cap_q[g] <= code_in[BIT];
        end
    end

    assert_step_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(step_q));
    assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take && last_step |=> step_q == '0);
    assert_step_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take && !last_step |=> step_q == $past(step_q) + 1'b1);
endmodule

// File: rtl/cci_hold_timer.sv
// Loadable down-counter for the result holds.
// 'load' writes load_val; otherwise the count falls by one per cycle
// until it stops at zero. 'expired' flags a count of zero. Assumes the
// loaded value is the hold length minus one.
module cci_hold_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    // Count register: load wins, else decrement while non-zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (!expired)
            cnt_q <= cnt_q - 1'b1;
    end

    assert_timer_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    assert_timer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
    assert_timer_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load && cnt_q == '0 |=> cnt_q == '0);
endmodule

// File: rtl/cci_control.sv
// Phase controller for the code-check indicator.
// It walks entry -> check -> pass or fail hold -> entry. It gates the
// strobe into captures, picks the timer reload for the hold being entered,
// decodes the indicator lines and raises the completion pulse.
// Assumes the timer is loaded in the check cycle.
module cci_control
    import cci_pkg::*;
#(
    parameter int               CNT_W     = 8,
    parameter logic [CNT_W-1:0] PASS_LOAD = '1,
    parameter logic [CNT_W-1:0] FAIL_LOAD = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             last_step,
    input  logic             code_ok,
    input  logic             expired,
    output logic             take,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic [2:0]       ind,
    output logic             done
);
    phase_t phase_q, phase_d;
    logic   in_hold;
    logic   done_q;

    assign in_hold  = (phase_q == PH_PASS) || (phase_q == PH_FAIL);
    assign take     = strobe && (phase_q == PH_ENTRY);
    assign load     = (phase_q == PH_CHECK);
    assign load_val = code_ok ? PASS_LOAD : FAIL_LOAD;
    assign done     = done_q;

    // Next phase
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_ENTRY: if (take && last_step) phase_d = PH_CHECK;
            PH_CHECK: phase_d = code_ok ? PH_PASS : PH_FAIL;
            PH_PASS:  if (expired) phase_d = PH_ENTRY;
            PH_FAIL:  if (expired) phase_d = PH_ENTRY;
            default:  phase_d = PH_ENTRY;
        endcase
    end

    // Indicator decode from the phase
    always_comb begin
        unique case (phase_q)
            PH_PASS: ind = 3'b010;
            PH_FAIL: ind = 3'b001;
            default: ind = 3'b100;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_ENTRY;
        else
            phase_q <= phase_d;
    end

    // Completion pulse, one cycle after the last hold cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= in_hold && expired;
    end

    assert_check_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_CHECK |=> phase_q == ($past(code_ok) ? PH_PASS : PH_FAIL));
    assert_entry_to_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_ENTRY && strobe && last_step |=> phase_q == PH_CHECK);
    assert_hold_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold && !expired |=> phase_q == $past(phase_q));
    assert_hold_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold && expired |=> phase_q == PH_ENTRY && done_q);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/code_check_indicator.sv
// Top of the timed code-check result indicator.
// It derives the hold lengths in cycles from CLK_HZ and the hold seconds,
// sizes the counter for the longer hold, and wires capture, timer and
// controller. Assumes both holds are at least one cycle long and that
// CLK_HZ * PASS_SEC fits in 31 bits.
module code_check_indicator
    import cci_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int PASS_SEC = 3,
    parameter int FAIL_SEC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [CODE_W-1:0] code_in,
    output logic [2:0]        ind,
    output logic              done
);
    localparam int PASS_CYC = CLK_HZ * PASS_SEC;
    localparam int FAIL_CYC = CLK_HZ * FAIL_SEC;
    localparam int MAX_CYC  = (PASS_CYC > FAIL_CYC) ? PASS_CYC : FAIL_CYC;
    localparam int CNT_W    = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] PASS_LOAD = CNT_W'(PASS_CYC - 1);
    localparam logic [CNT_W-1:0] FAIL_LOAD = CNT_W'(FAIL_CYC - 1);

    logic             take;
    logic             last_step;
    logic             code_ok;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;

    cci_capture #(
        .STEPS    (NUM_TAPS)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .code_in  (code_in),
        .last_step(last_step),
        .code_ok  (code_ok)
    );

    cci_hold_timer #(
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    cci_control #(
        .CNT_W    (CNT_W),
        .PASS_LOAD(PASS_LOAD),
        .FAIL_LOAD(FAIL_LOAD)
    ) u_control (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .last_step(last_step),
        .code_ok  (code_ok),
        .expired  (expired),
        .take     (take),
        .load     (load),
        .load_val (load_val),
        .ind      (ind),
        .done     (done)
    );

    assert_ind_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ind) == 1);
endmodule

// File: tb/tb_code_check_indicator.sv
// Self-checking bench: directed corner cases plus seeded random codes.
module tb_code_check_indicator;
    localparam int TB_HZ  = 20;
    localparam int PASS_N = TB_HZ * 3;
    localparam int FAIL_N = TB_HZ * 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [7:0] code_in = '0;
    logic [2:0] ind;
    logic       done;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    logic [2:0]  s_ind;
    logic        s_done;
    int unsigned seed_sink;

    always #10 clk = ~clk;

    code_check_indicator #(.CLK_HZ(TB_HZ), .PASS_SEC(3), .FAIL_SEC(2)) dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .code_in(code_in), .ind(ind), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Input bit sampled at entry step k (R3)
    function automatic int tap_of(input int k);
        case (k)
            0: return 7;
            1: return 6;
            2: return 5;
            default: return 3;
        endcase
    endfunction

    // Random switch word with the tap for step k forced to b
    function automatic logic [7:0] mk(input int k, input bit b);
        logic [7:0] v;
        v = 8'($urandom);
        v[tap_of(k)] = b;
        return v;
    endfunction

    // Sample outputs at the falling edge, away from the active edge
    task automatic samp();
        @(negedge clk);
        s_ind  = ind;
        s_done = done;
    endtask

    // Key one code and follow the result hold.
    // bits[k] is the value for step k; pre=1 means step 0 was already taken.
    task automatic run_code(input logic [3:0] bits, input int idle_max, input bit noise,
                            input bit pre, input bit sd, input bit nb);
        logic [2:0] exp_ind;
        int len;
        int cnt;
        bit fin;
        for (int k = (pre ? 1 : 0); k < 4; k++) begin
            int idle;
            idle = $urandom_range(0, idle_max);
            for (int i = 0; i < idle; i++) begin
                samp();
                chk(s_ind == 3'b100, "R4 step waits without strobe", s_ind, 3'b100);
                strobe  = 1'b0;
                code_in = 8'($urandom);
            end
            samp();
            chk(s_ind == 3'b100, "R2 busy during entry", s_ind, 3'b100);
            strobe  = 1'b1;
            code_in = mk(k, bits[k]);
        end
        samp();
        chk(s_ind == 3'b100 && !s_done, "R5 check cycle shows busy", {s_done, s_ind}, 3'b100);
        strobe  = noise;
        code_in = 8'($urandom);
        exp_ind = (&bits) ? 3'b010 : 3'b001;
        len     = (&bits) ? PASS_N : FAIL_N;
        cnt     = 0;
        fin     = 1'b0;
        while (!fin) begin
            samp();
            if (s_ind == exp_ind && cnt < len + 4) begin
                cnt++;
                chk(!s_done, "R8 done low during hold", s_done, 0);
                strobe  = noise ? 1'($urandom) : 1'b0;
                code_in = 8'($urandom);
            end else begin
                fin = 1'b1;
            end
        end
        chk(cnt > 0, "R5 result indicator shown", cnt, len);
        if (&bits)
            chk(cnt == len, "R6 pass hold length", cnt, len);
        else
            chk(cnt == len, "R7 fail hold length", cnt, len);
        chk(s_ind == 3'b100 && s_done, "R8 done after hold", {s_done, s_ind}, 4'b1100);
        strobe  = sd;
        code_in = mk(0, nb);
        samp();
        chk(!s_done && s_ind == 3'b100, "R8 done one cycle", {s_done, s_ind}, 3'b100);
        strobe  = 1'b0;
        code_in = 8'($urandom);
    endtask

    // Issue n entry strobes without finishing the code
    task automatic partial(input int n);
        for (int k = 0; k < n; k++) begin
            samp();
            strobe  = 1'b1;
            code_in = mk(k, 1'b1);
        end
        samp();
        strobe = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        seed_sink = $urandom(32'd2024);
        rst_n = 1'b0;
        repeat (3) samp();
        chk(s_ind == 3'b100 && !s_done, "R1 reset state", {s_done, s_ind}, 3'b100);
        rst_n = 1'b1;

        // Directed: pass, each single wrong bit, all wrong
        run_code(4'b1111, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_code(4'b1110, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_code(4'b1101, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_code(4'b1011, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_code(4'b0111, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_code(4'b0000, 1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R4: long idle gaps between strobes
        run_code(4'b1111, 25, 1'b0, 1'b0, 1'b0, 1'b0);

        // R9: strobes during check and hold are dropped
        run_code(4'b1111, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        run_code(4'b0101, 2, 1'b1, 1'b0, 1'b0, 1'b0);

        // R10: strobe in the done cycle starts the next code
        run_code(4'b1111, 1, 1'b0, 1'b0, 1'b1, 1'b1);
        run_code(4'b1111, 1, 1'b0, 1'b1, 1'b1, 1'b0);
        run_code(4'b1110, 1, 1'b0, 1'b1, 1'b0, 1'b0);

        // R1: reset in the middle of entry
        partial(2);
        rst_n = 1'b0;
        samp();
        chk(s_ind == 3'b100 && !s_done, "R1 reset during entry", {s_done, s_ind}, 3'b100);
        rst_n = 1'b1;
        run_code(4'b1111, 1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R1: reset in the middle of a hold
        partial(4);
        repeat (5) samp();
        chk(s_ind == 3'b010, "R6 hold started before reset", s_ind, 3'b010);
        rst_n = 1'b0;
        samp();
        chk(s_ind == 3'b100 && !s_done, "R1 reset during hold", {s_done, s_ind}, 3'b100);
        rst_n = 1'b1;
        run_code(4'b0110, 1, 1'b0, 1'b0, 1'b0, 1'b0);

        // Seeded random codes, R3 other bits random, mixed noise
        for (int r = 0; r < 16; r++) begin
            run_code(4'($urandom), 4, 1'($urandom), 1'b0, 1'b0, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule